// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the control side of a byte-wide parallel NOR flash, recast as a synchronous design. A bus front end hands it write strobes and read requests. Each write strobe carries an already latched address and data byte. The decoder follows keyed unlock cycles and starts byte programs, sector erases and whole-array erases. A down-counter stands in for the duration of each internal operation. The decoder can also switch into an identification mode, in which reads return fixed codes in place of array contents.

While an internal operation runs, the decoder drops every write. Reads then return a status byte and not stored data: bit 7 is a polarity flag, bit 6 changes on each read, and the remaining bits read as zero. A behavioural byte array of 2^MEM_AW entries holds the contents. It covers the low end of the address space. Addresses above it read as erased and cannot be altered.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the array reads FFh at every address, identification mode is off and no operation is busy; rdata is updated only on a clock edge where rd_en is high and holds otherwise, and writes during reset have no effect.
- R2: A byte program is four accepted writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then any address with its data; the stored byte becomes the old byte ANDed with that data.
- R3: A sector erase is six accepted writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 20h at any address inside the sector; the 128 bytes sharing that address's bits above bit 6 become FFh and all others keep their value.
- R4: A chip erase is the same five opening writes followed by 10h at 555h; every byte becomes FFh.
- R5: Only address bits 14..0 are compared on command cycles; any write that does not match the expected address and data returns the decoder to plain read mode, so later writes that would have continued the sequence start nothing.
- R6: Every write arriving while an operation is busy is discarded, including an F0h exit write, and leaves both the array and the command state untouched.
- R7: After the write that starts an operation, reads on the next N clock edges return status, where N is PGM_CYC, SEC_CYC or CHIP_CYC for program, sector erase or chip erase; the read on edge N+1 returns data.
- R8: A busy read returns bits 5..0 as 0; bit 7 is the inverse of bit 7 of the byte being programmed, or 0 during either erase.
- R9: Bit 6 of successive busy reads alternates, starting from 0 after reset and continuing across operations; reads while idle do not change it.
- R10: Identification entry is AAh@555h, 55h@2AAh, 90h@555h; while in that mode a read with address bit 0 clear returns BFh and one with bit 0 set returns DEV_CODE.
- R11: Identification mode is left either by one F0h write at any address or by AAh@555h, 55h@2AAh, F0h@555h.
- R12: A byte address whose bits above MEM_AW-1 are not all zero reads FFh, and programming or erasing it changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one bus write cycle per high clock |
| rd_en | input | 1 | Read request, captured into rdata on the same edge |
| addr | input | ADDR_W | Byte address for the current read or write |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data or status byte |

## Verification
The bench builds the block with ADDR_W 18 and MEM_AW 9. That leaves four sectors and 512 stored bytes, so every byte can be programmed, read back and compared against a shadow copy in a single run. High address bits above the storage range can also be driven, both on command cycles and on targets out of range. Busy counts of 5, 9 and 13 cycles keep the three operation lengths distinct. With them, each status window is counted read by read, and writes and reads can be interleaved inside a window. A device code of 5Ah cannot be mistaken for the manufacturer code or for erased data.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam int CMP_W     = 15;
    localparam int SECTOR_LG = 7;

    localparam logic [CMP_W-1:0] ADR_KEY1 = 15'h555;
    localparam logic [CMP_W-1:0] ADR_KEY2 = 15'h2AA;

    localparam logic [7:0] KEY_A    = 8'hAA;
    localparam logic [7:0] KEY_B    = 8'h55;
    localparam logic [7:0] CMD_PGM  = 8'hA0;
    localparam logic [7:0] CMD_ERS  = 8'h80;
    localparam logic [7:0] CMD_SEC  = 8'h20;
    localparam logic [7:0] CMD_CHIP = 8'h10;
    localparam logic [7:0] CMD_ID   = 8'h90;
    localparam logic [7:0] CMD_EXIT = 8'hF0;
    localparam logic [7:0] MFR_CODE = 8'hBF;
    localparam logic [7:0] ERASED   = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_PGM,
        SQ_E3,
        SQ_E4,
        SQ_E5
    } seq_st_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_SEC,
        OP_CHIP
    } op_kind_t;

    typedef struct packed {
        logic is_pgm;
        logic dq7;
    } busy_stat_t;

    function automatic logic cyc_hit(input logic [CMP_W-1:0] a, input logic [7:0] d,
                                     input logic [CMP_W-1:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/flash_seq.sv
module flash_seq
    import flash_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             busy,
    input  logic [CMP_W-1:0] ca,
    input  logic [7:0]       wdata,
    output logic             start,
    output op_kind_t         kind,
    output logic             id_mode
);

    seq_st_t st, st_nxt;
    logic    id_nxt;
    logic    wr_ok;

    assign wr_ok = wr_en && !busy;

    always_comb begin
        st_nxt = st;
        id_nxt = id_mode;
        start  = 1'b0;
        kind   = OP_NONE;
        if (wr_ok) begin
            if (st == SQ_PGM) begin
                start  = 1'b1;
                kind   = OP_PGM;
                st_nxt = SQ_IDLE;
            end else if (wdata == CMD_EXIT) begin
                id_nxt = 1'b0;
                st_nxt = SQ_IDLE;
            end else begin
                st_nxt = SQ_IDLE;
                case (st)
                    SQ_IDLE: if (cyc_hit(ca, wdata, ADR_KEY1, KEY_A)) st_nxt = SQ_K1;
                    SQ_K1:   if (cyc_hit(ca, wdata, ADR_KEY2, KEY_B)) st_nxt = SQ_K2;
                    SQ_K2: begin
                        if (ca == ADR_KEY1) begin
                            if (wdata == CMD_PGM)      st_nxt = SQ_PGM;
                            else if (wdata == CMD_ERS) st_nxt = SQ_E3;
                            else if (wdata == CMD_ID)  id_nxt = 1'b1;
                        end
                    end
                    SQ_E3:   if (cyc_hit(ca, wdata, ADR_KEY1, KEY_A)) st_nxt = SQ_E4;
                    SQ_E4:   if (cyc_hit(ca, wdata, ADR_KEY2, KEY_B)) st_nxt = SQ_E5;
                    SQ_E5: begin
                        if (wdata == CMD_SEC) begin
                            start = 1'b1;
                            kind  = OP_SEC;
                        end else if (cyc_hit(ca, wdata, ADR_KEY1, CMD_CHIP)) begin
                            start = 1'b1;
                            kind  = OP_CHIP;
                        end
                    end
                    default: st_nxt = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            st      <= st_nxt;
            id_mode <= id_nxt;
        end
    end

    AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> st == SQ_IDLE); // R6

    AST_ID_EXIT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && wdata == CMD_EXIT && st != SQ_PGM) |=> !id_mode); // R11

    AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(id_mode)); // R6

endmodule

// File: rtl/flash_timer.sv
module flash_timer
    import flash_pkg::*;
#(
    parameter int PGM_CYC  = 20,
    parameter int SEC_CYC  = 400,
    parameter int CHIP_CYC = 2000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  op_kind_t kind,
    output logic     busy
);

    localparam int MAXC  = max3(PGM_CYC, SEC_CYC, CHIP_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load;

    always_comb begin
        case (kind)
            OP_PGM:  load = CNT_W'(PGM_CYC);
            OP_SEC:  load = CNT_W'(SEC_CYC);
            OP_CHIP: load = CNT_W'(CHIP_CYC);
            default: load = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= load;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R7

    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy); // R7

endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_pkg::*;
#(
    parameter int         ADDR_W   = 18,
    parameter int         MEM_AW   = 10,
    parameter logic [7:0] DEV_CODE = 8'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_kind_t          kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              id_mode,
    input  logic              rd_en,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << MEM_AW;
    localparam int SEC_N = 1 << SECTOR_LG;

    logic [7:0]                  mem [DEPTH];
    logic [MEM_AW-1:0]           idx;
    logic [MEM_AW-SECTOR_LG-1:0] sec;
    logic                        in_rng;
    busy_stat_t                  stat;
    logic                        tog;
    logic                        last_rd_busy;
    logic [7:0]                  rd_val;

    assign idx = addr[MEM_AW-1:0];
    assign sec = addr[MEM_AW-1:SECTOR_LG];

    generate
        if (MEM_AW < ADDR_W) begin : g_hi
            assign in_rng = (addr[ADDR_W-1:MEM_AW] == '0);
        end else begin : g_full
            assign in_rng = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (start) begin
            case (kind)
                OP_PGM: if (in_rng) mem[idx] <= mem[idx] & wdata;
                OP_SEC: if (in_rng)
                    for (int j = 0; j < SEC_N; j++) mem[{sec, j[SECTOR_LG-1:0]}] <= ERASED;
                OP_CHIP:
                    for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
                default: ;
            endcase
        end
    end

    always_comb begin
        if (busy)         rd_val = {stat.dq7, tog, 6'b0};
        else if (id_mode) rd_val = addr[0] ? DEV_CODE : MFR_CODE;
        else if (in_rng)  rd_val = mem[idx];
        else              rd_val = ERASED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata        <= 8'h00;
            tog          <= 1'b0;
            last_rd_busy <= 1'b0;
            stat         <= '0;
        end else begin
            if (start) begin
                stat.is_pgm <= (kind == OP_PGM);
                stat.dq7    <= (kind == OP_PGM) ? ~wdata[7] : 1'b0;
            end
            if (rd_en) begin
                rdata        <= rd_val;
                last_rd_busy <= busy;
                if (busy) tog <= ~tog;
            end
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R1

    AST_ERASE_DQ7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && !stat.is_pgm) |=> rdata[7] == 1'b0); // R8

    AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> rdata[5:0] == 6'b0); // R8

    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && last_rd_busy) |=> rdata[6] != $past(rdata[6])); // R9

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_pkg::*;
#(
    parameter int         ADDR_W   = 18,
    parameter int         MEM_AW   = 10,
    parameter logic [7:0] DEV_CODE = 8'h3C,
    parameter int         PGM_CYC  = 20,
    parameter int         SEC_CYC  = 400,
    parameter int         CHIP_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic     start;
    op_kind_t kind;
    logic     id_mode;
    logic     busy;

    flash_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .busy    (busy),
        .ca      (addr[CMP_W-1:0]),
        .wdata   (wdata),
        .start   (start),
        .kind    (kind),
        .id_mode (id_mode)
    );

    flash_timer #(
        .PGM_CYC  (PGM_CYC),
        .SEC_CYC  (SEC_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .kind  (kind),
        .busy  (busy)
    );

    flash_store #(
        .ADDR_W   (ADDR_W),
        .MEM_AW   (MEM_AW),
        .DEV_CODE (DEV_CODE)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .kind    (kind),
        .addr    (addr),
        .wdata   (wdata),
        .busy    (busy),
        .id_mode (id_mode),
        .rd_en   (rd_en),
        .rdata   (rdata)
    );

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start); // R6

    AST_START_HAS_KIND: assert property (@(posedge clk) disable iff (rst)
        start |-> kind != OP_NONE); // R2

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    localparam int         AW    = 18;
    localparam int         MW    = 9;
    localparam int         DEPTH = 1 << MW;
    localparam int         NP    = 5;
    localparam int         NS    = 9;
    localparam int         NC    = 13;
    localparam logic [7:0] DEV   = 8'h5A;
    localparam logic [AW-1:0] HI  = 18'h2_8000;
    localparam logic [AW-1:0] A1  = HI | 18'h555;
    localparam logic [AW-1:0] A2  = HI | 18'h2AA;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata;

    always #5 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W   (AW),
        .MEM_AW   (MW),
        .DEV_CODE (DEV),
        .PGM_CYC  (NP),
        .SEC_CYC  (NS),
        .CHIP_CYC (NC)
    ) u0 (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    int         n_chk  = 0;
    int         n_fail = 0;
    logic [7:0] shadow [DEPTH];
    logic       exp_tog = 1'b0;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic status_reads(input int n, input logic dq7, input string tag);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            rd('0, v);
            chk(tag, v, {dq7, exp_tog, 6'b0});
            exp_tog = ~exp_tog;
        end
    endtask

    task automatic pgm_seq(input logic [AW-1:0] a, input logic [7:0] d);
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(a, d);
        if (a[AW-1:MW] == '0) shadow[a[MW-1:0]] = shadow[a[MW-1:0]] & d;
    endtask

    task automatic erase_head();
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h80); wr(A1, 8'hAA); wr(A2, 8'h55);
    endtask

    task automatic sec_seq(input logic [AW-1:0] a);
        erase_head();
        wr(a, 8'h20);
        if (a[AW-1:MW] == '0)
            for (int j = 0; j < 128; j++) shadow[{a[MW-1:7], j[6:0]}] = 8'hFF;
    endtask

    task automatic verify_all(input string tag);
        for (int i = 0; i < DEPTH; i++) rd_chk(tag, AW'(i), shadow[i]);
    endtask

    function automatic logic [7:0] pat1(input int i);
        return 8'(i * 7 + 3) ^ 8'(i >> 3);
    endfunction

    function automatic logic [7:0] pat2(input int i);
        return 8'(i * 13 + 90);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        @(negedge clk);
        wr_en = 1'b1; addr = '0; wdata = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 reset rdata", rdata, 8'h00);
        rd_chk("R1 erased low", 18'h000, 8'hFF);
        rd_chk("R1 erased high", 18'h1FF, 8'hFF);
        rd_chk("R1 no id mode", 18'h001, 8'hFF);
        @(negedge clk);
        chk("R1 rdata holds", rdata, 8'hFF);

        // R2 R7 R8 R9 program every byte
        for (int i = 0; i < DEPTH; i++) begin
            pgm_seq(AW'(i), pat1(i));
            status_reads(NP, ~pat1(i)[7], "R7 R8 R9 program status");
        end
        verify_all("R2 program sweep");

        // R2 program again: AND of old and new
        for (int i = 0; i < DEPTH; i += 3) begin
            pgm_seq(AW'(i), pat2(i));
            status_reads(NP, ~pat2(i)[7], "R7 program status");
        end
        verify_all("R2 and-merge");

        // R3 sector erase with high command address bits set
        sec_seq(18'h0_0155);
        status_reads(NS, 1'b0, "R7 R8 sector status");
        verify_all("R3 sector erase");

        // R12 out of range byte
        pgm_seq(18'h1_0005, 8'h00);
        status_reads(NP, 1'b1, "R7 out-of-range status");
        rd_chk("R12 alias untouched", 18'h0_0005, shadow[5]);
        rd_chk("R12 out-of-range reads FF", 18'h1_0005, 8'hFF);

        // R5 aborts
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h77); wr(A1, 8'hA0); wr(18'h0C3, 8'h00);
        rd_chk("R5 bad cmd byte abort", 18'h0C3, shadow[9'h0C3]);
        wr(A1, 8'hAA); wr(HI | 18'h2AB, 8'h55); wr(A1, 8'hA0); wr(18'h0C4, 8'h00);
        rd_chk("R5 bad addr abort", 18'h0C4, shadow[9'h0C4]);
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h80); wr(A1, 8'hAA); wr(HI | 18'h2AB, 8'h55);
        wr(A1, 8'h10);
        rd_chk("R5 erase abort not busy", 18'h0C5, shadow[9'h0C5]);
        erase_head();
        wr(HI | 18'h556, 8'h10);
        verify_all("R5 chip erase wrong addr");

        // R6 writes during busy are dropped
        sec_seq(18'h0_0010);
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(18'h100, 8'h00);
        status_reads(NS - 4, 1'b0, "R6 R8 status after dropped writes");
        rd_chk("R6 dropped program", 18'h100, shadow[9'h100]);
        pgm_seq(18'h101, 8'h0F);
        status_reads(NP, 1'b1, "R6 R7 program after busy");
        verify_all("R6 after busy");

        // R10 identification mode
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h90);
        rd_chk("R10 mfr code", HI, 8'hBF);
        rd_chk("R10 dev code", 18'h001, DEV);
        rd_chk("R10 dev code high addr", 18'h3FFFF, DEV);
        rd_chk("R10 mfr code high addr", 18'h3FFFE, 8'hBF);

        // R11 single-write exit
        wr(18'h12345, 8'hF0);
        rd_chk("R11 single exit", 18'h101, shadow[9'h101]);
        rd_chk("R11 single exit addr0", 18'h000, shadow[0]);

        // R11 three-cycle exit
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h90);
        rd_chk("R10 re-entry", 18'h000, 8'hBF);
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hF0);
        rd_chk("R11 three-cycle exit", 18'h000, shadow[0]);

        // R6 exit write while busy is ignored
        wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h90);
        pgm_seq(18'h1F0, 8'h33);
        wr(18'h00777, 8'hF0);
        status_reads(NP - 1, 1'b1, "R6 R8 status in id mode");
        rd_chk("R6 id survives busy exit", 18'h000, 8'hBF);
        wr(18'h0, 8'hF0);
        rd_chk("R2 program done in id mode", 18'h1F0, shadow[9'h1F0]);

        // R4 chip erase
        erase_head();
        wr(A1, 8'h10);
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        status_reads(NC, 1'b0, "R7 R8 chip status");
        verify_all("R4 chip erase");

        // R9 idle reads do not move the toggle
        pgm_seq(18'h002, 8'h7E);
        status_reads(1, 1'b1, "R9 first busy read");
        status_reads(NP - 1, 1'b1, "R9 rest busy reads");
        rd_chk("R2 final byte", 18'h002, 8'h7E);

        finish_run();
    end

endmodule